// File: doc/BRIEF.md
# Byte Arithmetic and Shift Unit with Condition Flags

This block is the combinational arithmetic core of a small accumulator processor. One cycle's operands go in: an accumulator value, a second operand, a carry input, a five-bit operation code and the present condition-code byte. Two things come out. The first is the new result with a write-enable that tells the register file whether to store it. The second is the next condition-code byte.

The condition-code byte uses a fixed layout. Bit 0 is carry/borrow (C), bit 1 is zero (Z), bit 2 is negative (N) and bit 3 is the interrupt mask (I). Bit 4 is half-carry (H), bits 5 and 6 always read as one, and bit 7 is overflow (V). The unit never changes I, except when it loads the whole byte from the accumulator.

Unary operations (shifts, rotates, increment, decrement, negate, complement, clear, nibble swap and loading the condition byte) work on the accumulator operand `opA` and ignore `opB`. Operand fetch, address generation and register storage are handled outside the block.

Top module: `alu8_flags`

## Requirements
- R1: ADD (code 0) and ADC (code 1, which adds `carryIn`) write the low 8 bits of the 9-bit sum r. C takes r bit 8. V takes bit 7 of a^b^r^(r>>1). H takes bit 4 of a^b^r.
- R2: SUB (code 2) and SBC (code 3, which also subtracts `carryIn`) write a-b taken modulo 512. C takes bit 8 of that value (the borrow), and V follows the same formula as R1. H keeps its input value.
- R3: CMP (code 4) computes a-b and sets N, Z, V and C as SUB would. It leaves `resultWe` low.
- R4: AND (5), OR (6) and XOR (7) write the bitwise result and clear V, leaving C and H unchanged. BIT (8) sets flags exactly as AND does but leaves `resultWe` low.
- R5: For ASR (9), LSR (10), LSL (11), ROL (12) and ROR (13), C takes the bit shifted out and V becomes the new N xor the new C. ASR keeps bit 7 and LSR clears it. ROL feeds `carryIn` into bit 0, and ROR feeds `carryIn` into bit 7.
- R6: INC (14) writes a+1 and sets V only when the result is 0x80. DEC (15) writes a-1 and sets V only when the result is 0x7F. Both leave C unchanged.
- R7: NEG (16) writes 0-a. It sets V only when the result is 0x80 and sets C whenever the result is nonzero.
- R8: COM (17) writes ~a, clears V and sets C. CLR (18) writes zero, clears V and leaves C unchanged.
- R9: SWAP (19) writes a with its two nibbles exchanged and leaves every flag unchanged.
- R10: CCLOAD (code 20) drives the condition-code output with `opA` OR 0x60 and leaves `resultWe` low.
- R11: For codes 0 to 18, N is bit 7 of the 8-bit result and Z is set exactly when that result is zero. This applies to CMP and BIT as well, even though they do not write.
- R12: Codes 21 to 31 leave `resultWe` low and pass the condition-code byte through unchanged. No code other than 20 changes bits 3, 5 or 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 8 | Accumulator operand |
| opB | input | 8 | Second operand for two-operand operations |
| carryIn | input | 1 | Carry input for ADC, SBC, ROL and ROR |
| opCode | input | 5 | Operation select |
| ccIn | input | 8 | Current condition-code byte |
| result | output | 8 | Computed result |
| resultWe | output | 1 | Result should be stored |
| ccOut | output | 8 | Next condition-code byte |

## Verification
The bench builds the unit with its default 8-bit data width. At that width, the single-operand codes and the unused codes can be swept over every accumulator value with both carry inputs. The two-operand codes take every accumulator value against 38 second operands, covering both ends of the range, so every sign, carry and borrow corner is reached. The condition-code input is varied with the operands, which shows that unchanged flags really are passed through.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int CC_W    = 8;
  localparam int CC_C    = 0;
  localparam int CC_Z    = 1;
  localparam int CC_N    = 2;
  localparam int CC_H    = 4;
  localparam int CC_V    = 7;
  localparam logic [CC_W-1:0] CC_FORCED = 8'h60;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
    OP_BIT = 5'd8,  OP_ASR = 5'd9,  OP_LSR = 5'd10, OP_LSL = 5'd11,
    OP_ROL = 5'd12, OP_ROR = 5'd13, OP_INC = 5'd14, OP_DEC = 5'd15,
    OP_NEG = 5'd16, OP_COM = 5'd17, OP_CLR = 5'd18, OP_SWAP = 5'd19,
    OP_CCLOAD = 5'd20
  } aluOp_e;

  typedef enum logic [2:0] {SH_ASR, SH_LSR, SH_LSL, SH_ROL, SH_ROR} shiftKind_e;
  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR} logicKind_e;
  typedef enum logic [2:0] {RS_ADDER, RS_LOGIC, RS_SHIFT, RS_COM, RS_CLR, RS_SWAP} resSel_e;
  typedef enum logic [2:0] {VS_KEEP, VS_ZERO, VS_ADDER, VS_SHIFT, VS_MINNEG, VS_MAXPOS} vSel_e;
  typedef enum logic [1:0] {CS_KEEP, CS_ADDER, CS_SHIFT, CS_ONE} cSel_e;

  typedef struct packed {
    resSel_e    resSel;
    shiftKind_e shiftKind;
    logicKind_e logicKind;
    logic       zeroX;
    logic       oneY;
    logic       subtract;
    logic       useCarry;
    vSel_e      vSel;
    cSel_e      cSel;
    logic       updH;
    logic       updNZ;
    logic       writeRes;
    logic       loadCc;
  } aluCtrl_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [4:0] opCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{resSel: RS_ADDER, shiftKind: SH_ASR, logicKind: LG_AND,
             zeroX: 1'b0, oneY: 1'b0, subtract: 1'b0, useCarry: 1'b0,
             vSel: VS_KEEP, cSel: CS_KEEP, updH: 1'b0, updNZ: 1'b0,
             writeRes: 1'b0, loadCc: 1'b0};
    case (opCode)
      OP_ADD, OP_ADC: begin
        ctrl.useCarry = (opCode == OP_ADC);
        ctrl.vSel = VS_ADDER; ctrl.cSel = CS_ADDER;
        ctrl.updH = 1'b1; ctrl.updNZ = 1'b1; ctrl.writeRes = 1'b1;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        ctrl.subtract = 1'b1;
        ctrl.useCarry = (opCode == OP_SBC);
        ctrl.vSel = VS_ADDER; ctrl.cSel = CS_ADDER;
        ctrl.updNZ = 1'b1; ctrl.writeRes = (opCode != OP_CMP);
      end
      OP_AND, OP_OR, OP_XOR, OP_BIT: begin
        ctrl.resSel = RS_LOGIC;
        ctrl.logicKind = (opCode == OP_OR)  ? LG_OR :
                         (opCode == OP_XOR) ? LG_XOR : LG_AND;
        ctrl.vSel = VS_ZERO; ctrl.updNZ = 1'b1;
        ctrl.writeRes = (opCode != OP_BIT);
      end
      OP_ASR, OP_LSR, OP_LSL, OP_ROL, OP_ROR: begin
        ctrl.resSel = RS_SHIFT;
        case (opCode)
          OP_LSR:  ctrl.shiftKind = SH_LSR;
          OP_LSL:  ctrl.shiftKind = SH_LSL;
          OP_ROL:  ctrl.shiftKind = SH_ROL;
          OP_ROR:  ctrl.shiftKind = SH_ROR;
          default: ctrl.shiftKind = SH_ASR;
        endcase
        ctrl.vSel = VS_SHIFT; ctrl.cSel = CS_SHIFT;
        ctrl.updNZ = 1'b1; ctrl.writeRes = 1'b1;
      end
      OP_INC, OP_DEC: begin
        ctrl.oneY = 1'b1;
        ctrl.subtract = (opCode == OP_DEC);
        ctrl.vSel = (opCode == OP_DEC) ? VS_MAXPOS : VS_MINNEG;
        ctrl.updNZ = 1'b1; ctrl.writeRes = 1'b1;
      end
      OP_NEG: begin
        ctrl.zeroX = 1'b1; ctrl.subtract = 1'b1;
        ctrl.vSel = VS_MINNEG; ctrl.cSel = CS_ADDER;
        ctrl.updNZ = 1'b1; ctrl.writeRes = 1'b1;
      end
      OP_COM: begin
        ctrl.resSel = RS_COM; ctrl.vSel = VS_ZERO; ctrl.cSel = CS_ONE;
        ctrl.updNZ = 1'b1; ctrl.writeRes = 1'b1;
      end
      OP_CLR: begin
        ctrl.resSel = RS_CLR; ctrl.vSel = VS_ZERO;
        ctrl.updNZ = 1'b1; ctrl.writeRes = 1'b1;
      end
      OP_SWAP: begin
        ctrl.resSel = RS_SWAP; ctrl.writeRes = 1'b1;
      end
      OP_CCLOAD: ctrl.loadCc = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic [CC_W-1:0]   ccIn,
  input  aluCtrl_t          ctrl,
  output logic [DATA_W-1:0] result,
  output logic [CC_W-1:0]   ccOut
);

  localparam int MSB      = DATA_W - 1;
  localparam int HALF     = DATA_W / 2;
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] addX, addY;
  logic [DATA_W:0]   addRaw, carryExt;
  logic              addV, addC, addH;
  logic [DATA_W-1:0] logicRes, shiftRes;
  logic              shiftOut;
  logic              nNew, zNew;

  // shared adder/subtractor
  always_comb begin
    addX     = ctrl.zeroX ? '0 : opA;
    addY     = ctrl.oneY ? DATA_W'(1) : (ctrl.zeroX ? opA : opB);
    carryExt = {{DATA_W{1'b0}}, ctrl.useCarry & carryIn};
    if (ctrl.subtract)
      addRaw = {1'b0, addX} - {1'b0, addY} - carryExt;
    else
      addRaw = {1'b0, addX} + {1'b0, addY} + carryExt;
    addC = addRaw[DATA_W];
    addV = addX[MSB] ^ addY[MSB] ^ addRaw[MSB] ^ addRaw[DATA_W];
    addH = addX[HALF] ^ addY[HALF] ^ addRaw[HALF];
  end

  always_comb begin
    case (ctrl.logicKind)
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = opA & opB;
    endcase
  end

  always_comb begin
    case (ctrl.shiftKind)
      SH_LSR: begin shiftRes = {1'b0, opA[MSB:1]};       shiftOut = opA[0];   end
      SH_LSL: begin shiftRes = {opA[MSB-1:0], 1'b0};     shiftOut = opA[MSB]; end
      SH_ROL: begin shiftRes = {opA[MSB-1:0], carryIn};  shiftOut = opA[MSB]; end
      SH_ROR: begin shiftRes = {carryIn, opA[MSB:1]};    shiftOut = opA[0];   end
      default: begin shiftRes = {opA[MSB], opA[MSB:1]};  shiftOut = opA[0];   end
    endcase
  end

  always_comb begin
    case (ctrl.resSel)
      RS_LOGIC: result = logicRes;
      RS_SHIFT: result = shiftRes;
      RS_COM:   result = ~opA;
      RS_CLR:   result = '0;
      RS_SWAP:  result = {opA[HALF-1:0], opA[MSB:HALF]};
      default:  result = addRaw[MSB:0];
    endcase
  end

  assign nNew = result[MSB];
  assign zNew = (result == '0);

  always_comb begin
    ccOut = ccIn;
    if (ctrl.updNZ) begin
      ccOut[CC_N] = nNew;
      ccOut[CC_Z] = zNew;
    end
    if (ctrl.updH) ccOut[CC_H] = addH;
    case (ctrl.cSel)
      CS_ADDER: ccOut[CC_C] = addC;
      CS_SHIFT: ccOut[CC_C] = shiftOut;
      CS_ONE:   ccOut[CC_C] = 1'b1;
      default:  ;
    endcase
    case (ctrl.vSel)
      VS_ZERO:   ccOut[CC_V] = 1'b0;
      VS_ADDER:  ccOut[CC_V] = addV;
      VS_SHIFT:  ccOut[CC_V] = nNew ^ shiftOut;
      VS_MINNEG: ccOut[CC_V] = (result == MIN_NEG);
      VS_MAXPOS: ccOut[CC_V] = (result == MAX_POS);
      default:   ;
    endcase
    if (ctrl.loadCc) ccOut = opA[CC_W-1:0] | CC_FORCED;
  end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic [4:0]        opCode,
  input  logic [CC_W-1:0]   ccIn,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic [CC_W-1:0]   ccOut
);

  aluCtrl_t ctrl;

  alu8_ctrl u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  alu8_datapath #(.DATA_W(DATA_W)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .ccIn    (ccIn),
    .ctrl    (ctrl),
    .result  (result),
    .ccOut   (ccOut)
  );

  assign resultWe = ctrl.writeRes;

endmodule

// File: rtl/alu8_flags_check.sv
module alu8_flags_check
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0] opA,
  input logic [4:0]        opCode,
  input logic [CC_W-1:0]   ccIn,
  input logic [DATA_W-1:0] result,
  input logic              resultWe,
  input logic [CC_W-1:0]   ccOut
);

  always_comb begin
    if (opCode == 5'd4) AST_CMP_NO_WRITE: assert (!resultWe); // R3
    if (opCode inside {5'd2, 5'd3, 5'd4}) AST_SUB_KEEPS_H: assert (ccOut[CC_H] == ccIn[CC_H]); // R2
    if (opCode inside {[5'd9:5'd13]}) AST_SHIFT_V_RULE: assert (ccOut[CC_V] == (ccOut[CC_N] ^ ccOut[CC_C])); // R5
    if (opCode == 5'd19) AST_SWAP_FLAGS_KEPT: assert (ccOut == ccIn); // R9
    if (opCode == 5'd20) AST_CCLOAD_FORCED: assert (!resultWe && ccOut == (opA[CC_W-1:0] | 8'h60)); // R10
    if (resultWe && opCode != 5'd19) AST_ZERO_FLAG: assert (ccOut[CC_Z] == (result == '0)); // R11
    if (opCode > 5'd20) AST_UNUSED_QUIET: assert (!resultWe && ccOut == ccIn); // R12
  end

endmodule

bind alu8_flags alu8_flags_check #(.DATA_W(DATA_W)) u_check (
  .opA      (opA),
  .opCode   (opCode),
  .ccIn     (ccIn),
  .result   (result),
  .resultWe (resultWe),
  .ccOut    (ccOut)
);

// File: tb/alu8_flags_test.sv
module alu8_flags_test;

  logic       clk = 1'b0;
  logic [7:0] opA = '0, opB = '0, ccIn = 8'h60;
  logic       carryIn = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] result, ccOut;
  logic       resultWe;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  alu8_flags uut (
    .opA(opA), .opB(opB), .carryIn(carryIn), .opCode(opCode), .ccIn(ccIn),
    .result(result), .resultWe(resultWe), .ccOut(ccOut)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int setb(input int v, input int pos, input int b);
    return (v & ~(1 << pos)) | ((b & 1) << pos);
  endfunction

  // returns {we, result, cc}
  function automatic logic [16:0] model(input int code, input int a, input int b,
                                        input int ci, input int cc);
    int r, res, we, c, sh, n;
    we = 1; res = 0; c = cc; r = 0; sh = 0;
    case (code)
      0, 1: begin
        r = a + b + ((code == 1) ? ci : 0);
        res = r & 255;
        c = setb(c, 0, r >> 8);
        c = setb(c, 7, (a ^ b ^ r ^ (r >> 1)) >> 7);
        c = setb(c, 4, (a ^ b ^ r) >> 4);
      end
      2, 3, 4: begin
        r = (a - b - ((code == 3) ? ci : 0)) & 511;
        res = r & 255;
        c = setb(c, 0, r >> 8);
        c = setb(c, 7, (a ^ b ^ r ^ (r >> 1)) >> 7);
        if (code == 4) we = 0;
      end
      5, 6, 7, 8: begin
        res = (code == 6) ? (a | b) : (code == 7) ? (a ^ b) : (a & b);
        c = setb(c, 7, 0);
        if (code == 8) we = 0;
      end
      9, 10, 11, 12, 13: begin
        case (code)
          9:  begin res = (a >> 1) | (a & 128); sh = a & 1; end
          10: begin res = a >> 1; sh = a & 1; end
          11: begin res = (a << 1) & 255; sh = a >> 7; end
          12: begin res = ((a << 1) | ci) & 255; sh = a >> 7; end
          default: begin res = (a >> 1) | (ci << 7); sh = a & 1; end
        endcase
        n = res >> 7;
        c = setb(c, 0, sh);
        c = setb(c, 7, n ^ sh);
      end
      14: begin res = (a + 1) & 255; c = setb(c, 7, (res == 128) ? 1 : 0); end
      15: begin res = (a + 255) & 255; c = setb(c, 7, (res == 127) ? 1 : 0); end
      16: begin
        res = (256 - a) & 255;
        c = setb(c, 7, (res == 128) ? 1 : 0);
        c = setb(c, 0, (res != 0) ? 1 : 0);
      end
      17: begin res = ~a & 255; c = setb(c, 7, 0); c = setb(c, 0, 1); end
      18: begin res = 0; c = setb(c, 7, 0); end
      19: res = ((a & 15) << 4) | (a >> 4);
      20: begin we = 0; c = a | 96; end
      default: we = 0;
    endcase
    if (code <= 18) begin
      c = setb(c, 2, res >> 7);
      c = setb(c, 1, (res == 0) ? 1 : 0);
    end
    return {we[0], res[7:0], c[7:0]};
  endfunction

  function automatic string reqOf(input int code);
    case (code)
      0, 1:   return "R1";
      2, 3:   return "R2";
      4:      return "R3";
      5, 6, 7, 8: return "R4";
      9, 10, 11, 12, 13: return "R5";
      14, 15: return "R6";
      16:     return "R7";
      17, 18: return "R8";
      19:     return "R9";
      20:     return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic applyCheck(input int code, input int a, input int b, input int ci, input int cc);
    logic [16:0] exp;
    opCode = code[4:0]; opA = a[7:0]; opB = b[7:0]; carryIn = ci[0]; ccIn = cc[7:0];
    #1;
    exp = model(code, a, b, ci, cc);
    checks = checks + 1;
    if (resultWe !== exp[16] || ccOut !== exp[7:0] || (exp[16] && result !== exp[15:8])) begin
      errors = errors + 1;
      $display("FAIL %s (R11 flags) code=%0d a=%02h b=%02h ci=%0d cc=%02h: we/res/cc=%0b/%02h/%02h expected %0b/%02h/%02h",
               reqOf(code), code, a, b, ci, cc, resultWe, result, ccOut, exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  task automatic directed(input int code, input int a, input int b, input int ci, input int cc,
                          input logic expWe, input logic [7:0] expRes, input logic [7:0] expCc,
                          input string tag);
    opCode = code[4:0]; opA = a[7:0]; opB = b[7:0]; carryIn = ci[0]; ccIn = cc[7:0];
    #1;
    checks = checks + 1;
    if (resultWe !== expWe || ccOut !== expCc || (expWe && result !== expRes)) begin
      errors = errors + 1;
      $display("FAIL %s: we/res/cc=%0b/%02h/%02h expected %0b/%02h/%02h",
               tag, resultWe, result, ccOut, expWe, expRes, expCc);
    end
  endtask

  initial begin
    // directed corners
    directed(0, 8'h7F, 8'h01, 0, 8'h60, 1, 8'h80, 8'hF4, "R1 signed overflow and half-carry");
    directed(1, 8'hFF, 8'h00, 1, 8'h60, 1, 8'h00, 8'h73, "R1 adc carry out to zero");
    directed(2, 8'h80, 8'h01, 0, 8'h70, 1, 8'h7F, 8'hF0, "R2 overflow, H kept");
    directed(3, 8'h00, 8'h00, 1, 8'h60, 1, 8'hFF, 8'h65, "R2 sbc borrow");
    directed(4, 8'h10, 8'h10, 0, 8'h60, 0, 8'h00, 8'h62, "R3 equal compare");
    directed(8, 8'hF0, 8'h0F, 0, 8'hE1, 0, 8'h00, 8'h63, "R4 bit test zero");
    directed(12, 8'h80, 8'h00, 1, 8'h60, 1, 8'h01, 8'hE1, "R5 rol carry in and out");
    directed(13, 8'h01, 8'h00, 1, 8'h60, 1, 8'h80, 8'h65, "R5 ror sets N and C");
    directed(14, 8'h7F, 8'h00, 0, 8'h61, 1, 8'h80, 8'hE5, "R6 inc overflow");
    directed(15, 8'h80, 8'h00, 0, 8'h60, 1, 8'h7F, 8'hE0, "R6 dec overflow");
    directed(16, 8'h80, 8'h00, 0, 8'h60, 1, 8'h80, 8'hE5, "R7 negate most negative");
    directed(16, 8'h00, 8'h00, 0, 8'h61, 1, 8'h00, 8'h62, "R7 negate zero clears C");
    directed(17, 8'h00, 8'h00, 0, 8'hE0, 1, 8'hFF, 8'h65, "R8 complement");
    directed(19, 8'h3C, 8'h00, 0, 8'h9B, 1, 8'hC3, 8'h9B, "R9 nibble swap keeps flags");
    directed(20, 8'h08, 8'h00, 0, 8'h00, 0, 8'h00, 8'h68, "R10 condition load forces bits");
    directed(27, 8'h55, 8'hAA, 1, 8'h6F, 0, 8'h00, 8'h6F, "R12 unused code quiet");

    // two-operand sweep: R1 R2 R3 R4 R11
    for (int code = 0; code <= 8; code++)
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi <= 37; bi++)
          for (int ci = 0; ci < 2; ci++) begin
            int b = (bi == 37) ? 255 : bi * 7;
            applyCheck(code, a, b, ci, 8'h60 | ((a * 3 + b + ci) & 8'h9F));
          end

    // single-operand, condition load and unused codes: R5..R10, R12
    for (int code = 9; code <= 31; code++)
      for (int a = 0; a < 256; a++)
        for (int ci = 0; ci < 2; ci++)
          applyCheck(code, a, a ^ 8'h5A, ci, (code == 20) ? (a * 5) & 255
                                                          : 8'h60 | ((a * 5 + ci) & 8'h9F));

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule